// File: doc/BRIEF.md
# Four-Stage Serial Receive Buffer

This block sits behind a UART receiver and stores completed frames. There are four receive buffers, and they are filled in rotation. A frame arrives as a one-cycle valid pulse that carries the data byte, the parity bit as received and the multiprocessor (MPC) bit. The block writes the byte into the buffer chosen by a 2-bit rotation counter and then advances the counter.

The block also keeps three sticky error flags for the last buffer (buffer 3): overrun, parity and multiprocessor error. Hardware sets these flags and the CPU clears them. The CPU reaches the four data buffers and one status register through a simple register port. Read data is registered.

Register addresses on `reg_addr`: 0 to 3 select data buffers 0 to 3, and 4 selects the status register. Any other address reads as 0x00 and ignores writes.

Top module: `rx_quad_buffer`

## Requirements
- R1: Each `frame_valid` pulse writes `frame_data` into the buffer given by the rotation counter, then increments the counter. The counter wraps from 3 to 0, so frames land in buffers 0,1,2,3,0,...
- R2: Status bits [5:4] show the rotation counter, which is the buffer the next frame will fill. Writes to the status register leave these bits unchanged.
- R3: Status bits 0, 6 and 7 always read 1. After reset the status register reads 0xC1 and the counter is 0.
- R4: Status bit 1 (overrun) sets when a frame is written into buffer 3 while the previous contents of buffer 3 are still unread. The new byte is stored anyway.
- R5: Status bit 2 (parity error) sets when a frame is written into buffer 3 and `frame_parity` differs from the expected bit. With `parity_odd`=0 the expected bit is the XOR of the 8 data bits. With `parity_odd`=1 it is that XOR inverted.
- R6: Status bit 3 (multiprocessor error) sets when a frame with `frame_mpc`=1 is written into buffer 3 while `mp_enable`=1 and `addr_accept`=0. In any other case it does not set.
- R7: Error bits 1 to 3 are sticky. A later error-free frame does not clear them. A status write with 0 in a bit clears that bit, and a 1 leaves it unchanged.
- R8: If the CPU clears the overrun bit while buffer 3 is still unread, the next frame into buffer 3 sets the overrun bit again.
- R9: If a status write clears an error bit in the same cycle that hardware sets it, the bit ends up set.
- R10: A read strobe returns the addressed register on `reg_rdata` from the next cycle, and the value holds until the next read. A data buffer read marks that buffer as read. A read of a buffer in the same cycle that a frame writes it returns the old byte, counts as reading the old contents, and leaves the new byte unread.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle pulse for a completed frame |
| frame_data | input | 8 | Received data byte |
| frame_parity | input | 1 | Parity bit as received |
| frame_mpc | input | 1 | Multiprocessor bit as received |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even parity |
| mp_enable | input | 1 | Multiprocessor mode enable |
| addr_accept | input | 1 | Address reception selected (suppresses the MPC error) |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 8 | Registered read data |

## Verification
Two pairs of functions can fall in the same cycle. In the first, a frame lands in buffer 3 on the same clock as a status write that clears the flag the frame is setting. In the second, a frame lands in buffer 3 on the same clock as a CPU read of buffer 3. The bench drives each pair deliberately on one clock edge. It then judges the outcome from the status value read back afterwards and from the byte returned by the colliding read. Both are compared against a behavioural reference model that applies the hardware-set-wins rule and the read-old-data rule. The model is checked on every clock.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int unsigned STAT_W = 8;
  // status bit positions
  localparam int unsigned ST_OVR  = 1;
  localparam int unsigned ST_PAR  = 2;
  localparam int unsigned ST_MP   = 3;
  localparam int unsigned ST_PTR0 = 4;

  typedef enum logic [1:0] {
    SRC_MEM  = 2'd0,
    SRC_STAT = 2'd1,
    SRC_NONE = 2'd2
  } rd_src_e;

  typedef struct packed {
    logic mp;
    logic par;
    logic ovr;
  } err_flags_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NBUF   = 4,
  localparam int unsigned PTR_W = $clog2(NBUF)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [NBUF];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  // read-first: a colliding read returns the old contents
  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxq_parity_chk.sv
module rxq_parity_chk #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic              par_bit,
  input  logic              odd,
  output logic              bad
);
  always_comb begin
    bad = par_bit ^ ((^data) ^ odd);
  end
endmodule

// File: rtl/rxq_status.sv
module rxq_status
  import rxq_pkg::*;
#(
  parameter int unsigned NBUF = 4,
  localparam int unsigned PTR_W = $clog2(NBUF),
  localparam int unsigned LAST  = NBUF - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_valid,
  input  logic             frame_mpc,
  input  logic             par_bad,
  input  logic             mp_enable,
  input  logic             addr_accept,
  input  logic [NBUF-1:0]  rd_hit,
  input  logic             st_wr,
  input  err_flags_t       st_keep,
  output logic [PTR_W-1:0] ptr,
  output logic [NBUF-1:0]  unread,
  output err_flags_t       flags
);
  logic [NBUF-1:0] fill_vec;
  logic            hit_last;
  err_flags_t      set_v;
  err_flags_t      kept;

  genvar gi;
  generate
    for (gi = 0; gi < NBUF; gi++) begin : g_fill
      assign fill_vec[gi] = frame_valid && (ptr == PTR_W'(gi));
    end
  endgenerate

  always_comb begin
    hit_last  = fill_vec[LAST];
    set_v.ovr = hit_last && unread[LAST] && !rd_hit[LAST];
    set_v.par = hit_last && par_bad;
    set_v.mp  = hit_last && mp_enable && !addr_accept && frame_mpc;
    kept      = st_wr ? (flags & st_keep) : flags;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      unread <= '0;
      flags  <= '0;
    end else begin
      if (frame_valid) ptr <= ptr + 1'b1;
      unread <= (unread & ~rd_hit) | fill_vec;
      flags  <= kept | set_v;
    end
  end
endmodule

// File: rtl/rx_quad_buffer.sv
module rx_quad_buffer
  import rxq_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned NBUF   = 4,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_valid,
  input  logic [DATA_W-1:0] frame_data,
  input  logic              frame_parity,
  input  logic              frame_mpc,
  input  logic              parity_odd,
  input  logic              mp_enable,
  input  logic              addr_accept,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_rd,
  output logic [DATA_W-1:0] reg_rdata
);
  localparam int unsigned PTR_W = $clog2(NBUF);
  localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NBUF);

  logic [PTR_W-1:0]  wr_ptr;
  logic [NBUF-1:0]   unread;
  logic [NBUF-1:0]   rd_hit;
  err_flags_t        flags;
  err_flags_t        st_keep;
  logic              st_wr;
  logic              st_rd;
  logic              buf_sel;
  logic              par_bad;
  logic [DATA_W-1:0] mem_q;
  logic [DATA_W-1:0] stat_vec;
  logic [DATA_W-1:0] stat_q;
  rd_src_e           src_q;

  assign buf_sel = reg_addr < STAT_ADDR;
  assign st_wr   = reg_wr && (reg_addr == STAT_ADDR);
  assign st_rd   = reg_rd && (reg_addr == STAT_ADDR);
  assign st_keep = '{mp: reg_wdata[ST_MP], par: reg_wdata[ST_PAR], ovr: reg_wdata[ST_OVR]};

  genvar gi;
  generate
    for (gi = 0; gi < NBUF; gi++) begin : g_hit
      assign rd_hit[gi] = reg_rd && (reg_addr == ADDR_W'(gi));
    end
  endgenerate

  always_comb begin
    stat_vec          = '1;
    stat_vec[ST_OVR]  = flags.ovr;
    stat_vec[ST_PAR]  = flags.par;
    stat_vec[ST_MP]   = flags.mp;
    stat_vec[ST_PTR0 +: PTR_W] = wr_ptr;
  end

  rxq_parity_chk #(.DATA_W(DATA_W)) u_par (
    .data    (frame_data),
    .par_bit (frame_parity),
    .odd     (parity_odd),
    .bad     (par_bad)
  );

  rxq_store #(.DATA_W(DATA_W), .NBUF(NBUF)) u_store (
    .clk   (clk),
    .we    (frame_valid),
    .waddr (wr_ptr),
    .wdata (frame_data),
    .re    (reg_rd && buf_sel),
    .raddr (reg_addr[PTR_W-1:0]),
    .rdata (mem_q)
  );

  rxq_status #(.NBUF(NBUF)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .frame_valid (frame_valid),
    .frame_mpc   (frame_mpc),
    .par_bad     (par_bad),
    .mp_enable   (mp_enable),
    .addr_accept (addr_accept),
    .rd_hit      (rd_hit),
    .st_wr       (st_wr),
    .st_keep     (st_keep),
    .ptr         (wr_ptr),
    .unread      (unread),
    .flags       (flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q  <= SRC_NONE;
      stat_q <= '0;
    end else if (reg_rd) begin
      if (buf_sel)    src_q <= SRC_MEM;
      else if (st_rd) src_q <= SRC_STAT;
      else            src_q <= SRC_NONE;
      if (st_rd) stat_q <= stat_vec;
    end
  end

  always_comb begin
    case (src_q)
      SRC_MEM:  reg_rdata = mem_q;
      SRC_STAT: reg_rdata = stat_q;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int unsigned NBUF = 4,
  localparam int unsigned PTR_W = $clog2(NBUF),
  localparam int unsigned LAST  = NBUF - 1
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_valid,
  input logic [PTR_W-1:0] ptr,
  input logic [NBUF-1:0]  unread,
  input logic [NBUF-1:0]  rd_hit,
  input logic             st_wr,
  input logic             par_bad,
  input logic             err_ovr,
  input logic             err_par,
  input logic             err_mp
);
  p_ptr_step_r1: assert property (@(posedge clk) disable iff (rst)
    frame_valid |=> ptr == PTR_W'($past(ptr) + 1'b1));

  p_ptr_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !frame_valid |=> $stable(ptr));

  p_ovr_set_r4: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && ptr == PTR_W'(LAST) && unread[LAST] && !rd_hit[LAST]) |=> err_ovr);

  p_ovr_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (err_ovr && !st_wr) |=> err_ovr);

  p_mp_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (err_mp && !st_wr) |=> err_mp);

  p_par_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && ptr == PTR_W'(LAST) && par_bad) |=> err_par);

  p_fill_marks_r10: assert property (@(posedge clk) disable iff (rst)
    (frame_valid && ptr == PTR_W'(LAST)) |=> unread[LAST]);
endmodule

bind rx_quad_buffer rxq_checker #(.NBUF(NBUF)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .frame_valid (frame_valid),
  .ptr         (wr_ptr),
  .unread      (unread),
  .rd_hit      (rd_hit),
  .st_wr       (st_wr),
  .par_bad     (par_bad),
  .err_ovr     (flags.ovr),
  .err_par     (flags.par),
  .err_mp      (flags.mp)
);

// File: tb/rx_quad_buffer_tb_top.sv
`timescale 1ns/1ps
module rx_quad_buffer_tb_top;
  localparam real CLK_HALF = 2.5; // 200 MHz

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       frame_valid = 1'b0;
  logic [7:0] frame_data = '0;
  logic       frame_parity = 1'b0;
  logic       frame_mpc = 1'b0;
  logic       parity_odd = 1'b0;
  logic       mp_enable = 1'b0;
  logic       addr_accept = 1'b0;
  logic [2:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic       reg_rd = 1'b0;
  logic [7:0] reg_rdata;

  int n_checks = 0;
  int n_errors = 0;

  // reference model state
  logic [7:0] m_buf [4];
  bit         m_unread [4];
  int         m_cnt = 0;
  bit         m_ovr = 0, m_par = 0, m_mp = 0;
  logic [7:0] m_rdata = 8'h00;

  always #(CLK_HALF) clk = ~clk;

  rx_quad_buffer dut_i (
    .clk(clk), .rst(rst), .frame_valid(frame_valid), .frame_data(frame_data),
    .frame_parity(frame_parity), .frame_mpc(frame_mpc), .parity_odd(parity_odd),
    .mp_enable(mp_enable), .addr_accept(addr_accept), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  function automatic logic [7:0] m_status();
    logic [1:0] c = 2'(m_cnt);
    return {2'b11, c, m_mp, m_par, m_ovr, 1'b1};
  endfunction

  function automatic bit good_par(input logic [7:0] d);
    return (^d) ^ parity_odd;
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: drive, update model, clock, compare
  task automatic cyc(input bit v, input logic [7:0] d, input bit p, input bit m,
                     input bit rd, input bit wr, input logic [2:0] a,
                     input logic [7:0] wd, input string tag);
    bit rd3, s_ovr, s_par, s_mp;
    @(negedge clk);
    frame_valid = v; frame_data = d; frame_parity = p; frame_mpc = m;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    if (rd) begin
      if (a < 4) m_rdata = m_buf[a];
      else if (a == 4) m_rdata = m_status();
      else m_rdata = 8'h00;
    end
    rd3 = rd && a == 3;
    s_ovr = 0; s_par = 0; s_mp = 0;
    if (v && m_cnt == 3) begin
      s_ovr = m_unread[3] && !rd3;
      s_par = (p != good_par(d));
      s_mp  = mp_enable && !addr_accept && m;
    end
    if (rd && a < 4) m_unread[a] = 0;
    if (v) begin m_buf[m_cnt] = d; m_unread[m_cnt] = 1; end
    if (wr && a == 4) begin
      m_ovr = m_ovr & wd[1]; m_par = m_par & wd[2]; m_mp = m_mp & wd[3];
    end
    m_ovr |= s_ovr; m_par |= s_par; m_mp |= s_mp;
    if (v) m_cnt = (m_cnt + 1) % 4;
    @(posedge clk); #1;
    check(tag, reg_rdata, m_rdata);
  endtask

  task automatic frame(input logic [7:0] d, input bit pbad, input bit m, input string tag);
    cyc(1, d, good_par(d) ^ pbad, m, 0, 0, 0, 0, tag);
  endtask
  task automatic rd_reg(input logic [2:0] a, input string tag);
    cyc(0, 0, 0, 0, 1, 0, a, 0, tag);
  endtask
  task automatic wr_stat(input logic [7:0] wd, input string tag);
    cyc(0, 0, 0, 0, 0, 1, 4, wd, tag);
  endtask

  initial begin
    #(CLK_HALF * 2 * 100000);
    n_errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_buf[i] = 8'h00; m_unread[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R3: reset value
    rd_reg(4, "R3 reset status");
    check("R3 reset 0xC1", reg_rdata, 8'hC1);

    // R1 / R10: rotation and read-back, even parity
    frame(8'h11, 0, 0, "R1 frame0");
    frame(8'h22, 0, 0, "R1 frame1");
    rd_reg(4, "R2 counter=2");
    check("R2 ptr bits", reg_rdata, 8'hE1);
    frame(8'h33, 0, 0, "R1 frame2");
    frame(8'h44, 0, 0, "R1 frame3");
    for (int a = 0; a < 4; a++) rd_reg(3'(a), "R10 buffer read");
    check("R1 buffer3 value", reg_rdata, 8'h44);
    rd_reg(6, "R10 unmapped");

    // R2: status write cannot move counter
    frame(8'h55, 0, 0, "R1 wrap to buf0");
    wr_stat(8'h00, "R2 write zero");
    wr_stat(8'hFF, "R2 write ones");
    rd_reg(4, "R2 counter=1 after writes");
    check("R2 readonly ptr", reg_rdata, 8'hD1);

    // R4: overrun; R7 sticky
    frame(8'h66, 0, 0, "R1 buf1");
    frame(8'h77, 0, 0, "R1 buf2");
    frame(8'h88, 0, 0, "R1 buf3 first");
    repeat (3) frame(8'h99, 0, 0, "R1 fill");
    frame(8'hAA, 0, 0, "R4 buf3 unread");
    rd_reg(4, "R4 ovr set");
    check("R4 overrun bit", reg_rdata[1], 1'b1);
    rd_reg(3, "R4 new data stored");
    check("R4 buf3 overwritten", reg_rdata, 8'hAA);

    // R8: clear without read reasserts
    wr_stat(8'hFD, "R7 clear ovr");
    rd_reg(4, "R7 ovr cleared");
    check("R7 cleared", reg_rdata[1], 1'b0);
    repeat (3) frame(8'h01, 0, 0, "R1 fill");
    frame(8'hBB, 0, 0, "R4 buf3 normal");
    wr_stat(8'hF1, "R8 clear without read");
    repeat (3) frame(8'h02, 0, 0, "R1 fill");
    frame(8'hCC, 0, 0, "R8 buf3 again");
    rd_reg(4, "R8 reasserted");
    check("R8 ovr again", reg_rdata[1], 1'b1);
    rd_reg(3, "R8 read buf3");
    wr_stat(8'hF1, "R7 clear all");

    // R5: odd parity error, then R7 sticky on clean frame
    parity_odd = 1'b1;
    repeat (3) frame(8'h03, 0, 0, "R5 fill odd");
    frame(8'h5A, 1, 0, "R5 bad parity");
    rd_reg(3, "R5 read buf3");
    repeat (3) frame(8'h04, 0, 0, "R5 fill");
    frame(8'h5B, 0, 0, "R7 clean frame");
    rd_reg(4, "R7 parity sticky");
    check("R7 parity kept", reg_rdata[2], 1'b1);
    rd_reg(3, "R5 read buf3");
    wr_stat(8'hFB, "R7 clear parity");
    parity_odd = 1'b0;

    // R6: multiprocessor error
    mp_enable = 1'b1; addr_accept = 1'b1;
    repeat (3) frame(8'h05, 0, 1, "R6 fill");
    frame(8'h06, 0, 1, "R6 address accepted");
    rd_reg(4, "R6 no mp error");
    check("R6 suppressed", reg_rdata[3], 1'b0);
    rd_reg(3, "R6 read buf3");
    addr_accept = 1'b0;
    repeat (3) frame(8'h07, 0, 1, "R6 fill");
    frame(8'h08, 0, 1, "R6 mpc in data");
    rd_reg(4, "R6 mp error");
    check("R6 mp set", reg_rdata[3], 1'b1);
    rd_reg(3, "R6 read buf3");
    mp_enable = 1'b0;

    // R9: clear and set in the same cycle
    repeat (3) frame(8'h09, 0, 0, "R9 fill");
    cyc(1, 8'h0A, good_par(8'h0A) ^ 1'b1, 0, 0, 1, 4, 8'hF1, "R9 collide");
    rd_reg(4, "R9 hw wins");
    check("R9 parity set wins", reg_rdata[2], 1'b1);
    check("R9 mp cleared", reg_rdata[3], 1'b0);
    wr_stat(8'hF1, "R7 clear all");

    // R10: read buf3 while frame writes buf3
    repeat (3) frame(8'h0B, 0, 0, "R10 fill");
    cyc(1, 8'hE7, good_par(8'hE7), 0, 1, 0, 3, 0, "R10 read collide");
    check("R10 old data", reg_rdata, 8'h0A);
    rd_reg(4, "R10 no overrun");
    check("R10 ovr clear", reg_rdata[1], 1'b0);
    repeat (3) frame(8'h0C, 0, 0, "R10 fill");
    frame(8'h0D, 0, 0, "R10 new byte unread");
    rd_reg(4, "R10 ovr from unread new");
    check("R10 new byte was unread", reg_rdata[1], 1'b1);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule